// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the two error counters of a CAN node, one for transmission faults and one for reception faults, and derives from them the node's fault-confinement state. The protocol engine reports what it has seen on the bus as single-cycle event pulses. Examples are a transmit error, a receive error, a good frame sent or received, a dominant bit after an error flag, a bit error while driving an active error or overload flag, and a completed run of dominant bits. Qualifier inputs accompany the pulses. They give the node's current role (transmitter or receiver) and flag the cases in which a counter must not move.

The outputs are the two counter values, a two-bit state code and a one-cycle pulse when the node goes bus-off. While bus-off, the counters are frozen. The recovery logic decides when the node may return, and then clears both counters through a dedicated input. Event detection at bit level and the recovery sequence itself sit outside the block.

Top module: `can_fault_confine`

## Requirements
- R1: A transmit error that carries no exception qualifier raises the transmit counter by 8.
- R2: A successful transmission lowers the transmit counter by 1. At 0 the counter stays at 0.
- R3: A receive error raises the receive counter by 1. It has no effect when the in-flag qualifier says the error was a bit error seen while sending an active error or overload flag.
- R4: In receiver role (role input 0), a dominant bit right after the node's own error flag raises the receive counter by 8. In transmitter role this event has no effect.
- R5: A bit error while sending an active error or overload flag adds 8 to the transmit counter when the role input is 1, and 8 to the receive counter when it is 0.
- R6: A dominant-run event (the 14-bit run after an active or overload flag, each further 8-bit run, or each 8-bit run after a passive flag) adds 8 to the counter of the current role.
- R7: A successful reception lowers the receive counter by 1 when the counter is from 1 to 127. It leaves the counter at 0 when it is 0, and sets it to 127 when it is above 127.
- R8: A transmit error flagged as an ACK error of an error-passive transmitter with no dominant bit during its passive flag leaves the transmit counter unchanged. So does a transmit error flagged as a stuff error during arbitration.
- R9: The state code is 2'b00 (error active) while both counters are at most 127. It is 2'b01 (error passive) when either counter exceeds 127 and the transmit counter is at most 255. After reset, both counters are 0 and the state is 2'b00.
- R10: The state code is 2'b10 (bus-off) exactly when the transmit counter exceeds 255. The bus-off pulse is high for the one cycle in which the state first shows 2'b10. The receive counter alone never causes bus-off.
- R11: While the state is bus-off, every event except the clear leaves both counters unchanged.
- R12: The clear input sets both counters to 0 on the next edge, and the state returns to 2'b00.
- R13: The receive counter saturates at 255 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| role_tx_i | input | 1 | 1 when the node is currently transmitter, 0 when receiver |
| tx_err_i | input | 1 | Transmit error pulse |
| tx_err_ackpass_i | input | 1 | Qualifier: ACK error of an error-passive transmitter with no dominant bit seen during its passive flag |
| tx_err_arbstuff_i | input | 1 | Qualifier: stuff error during arbitration |
| rx_err_i | input | 1 | Receive error pulse |
| rx_err_inflag_i | input | 1 | Qualifier: receive error was a bit error while sending an active error or overload flag |
| dom_after_flag_i | input | 1 | Dominant level on the first bit after the node's own error flag |
| flag_bit_err_i | input | 1 | Bit error while sending an active error or overload flag |
| dom_run_i | input | 1 | A counted run of dominant bits after an error or overload flag |
| tx_ok_i | input | 1 | Frame transmitted successfully |
| rx_ok_i | input | 1 | Frame received successfully |
| clr_i | input | 1 | Counter clear from the recovery logic |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| state_o | output | 2 | Fault-confinement state code |
| busoff_pulse_o | output | 1 | One-cycle pulse on entry to bus-off |

## Verification
The bench builds the block with its default parameters: a 9-bit transmit counter, an 8-bit receive counter, a step of 8 and a passive limit of 127. With these values, 32 transmit errors take the node from zero to bus-off. About thirty dominant-after-flag events drive the receive counter into saturation. This keeps the passive boundary at 127/128, the reload from above 127, saturation at 255 and the bus-off freeze all within a few hundred cycles.

// File: rtl/can_fc_pkg.sv
// Shared types of the CAN fault confinement block.
// Assumes: the state code values are decoded by neighbouring logic and stay fixed.
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_state_e;
endpackage

// File: rtl/can_fc_tec.sv
// Transmit error counter.
// Adds STEP on inc, or subtracts 1 on dec (floored at 0). Holds while frozen,
// and clears on clr. inc takes priority over dec.
// Assumes: at most one increment source per cycle, merged by the caller.
module can_fc_tec #(
    parameter int W    = 9,
    parameter int STEP = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         freeze,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] STEP_V = W'(STEP);
    localparam logic [W-1:0] MAX_V  = '1;
    localparam logic [W-1:0] HEAD_V = MAX_V - STEP_V;

    logic [W-1:0] nxt;

    // Next-value selection with saturating add and floored decrement.
    always_comb begin
        nxt = cnt;
        if (clr) begin
            nxt = '0;
        end else if (!freeze) begin
            if (inc) begin
                nxt = (cnt > HEAD_V) ? MAX_V : cnt + STEP_V;
            end else if (dec && cnt != '0) begin
                nxt = cnt - 1'b1;
            end
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end
endmodule

// File: rtl/can_fc_rec.sv
// Receive error counter.
// Adds BIG or SMALL (saturating), or handles success: 1..LIM decrements,
// 0 holds, and above LIM reloads to RELOAD. Holds while frozen, clears on clr.
// Assumes: a big step wins over a small one, and any increment wins over success.
module can_fc_rec #(
    parameter int W      = 8,
    parameter int SMALL  = 1,
    parameter int BIG    = 8,
    parameter int LIM    = 127,
    parameter int RELOAD = 127
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         freeze,
    input  logic         inc_small,
    input  logic         inc_big,
    input  logic         ok,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] SMALL_V  = W'(SMALL);
    localparam logic [W-1:0] BIG_V    = W'(BIG);
    localparam logic [W-1:0] LIM_V    = W'(LIM);
    localparam logic [W-1:0] RELOAD_V = W'(RELOAD);
    localparam logic [W-1:0] MAX_V    = '1;

    logic [W-1:0] nxt;

    // Saturating add of a given step.
    function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input logic [W-1:0] s);
        return (a > MAX_V - s) ? MAX_V : a + s;
    endfunction

    // Next-value selection by event priority.
    always_comb begin
        nxt = cnt;
        if (clr) begin
            nxt = '0;
        end else if (!freeze) begin
            if (inc_big)           nxt = sat_add(cnt, BIG_V);
            else if (inc_small)    nxt = sat_add(cnt, SMALL_V);
            else if (ok) begin
                if (cnt > LIM_V)   nxt = RELOAD_V;
                else if (cnt != '0) nxt = cnt - 1'b1;
            end
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end
endmodule

// File: rtl/can_fc_state.sv
// Fault-confinement state decode.
// Derives the state from the counter values and pulses once when bus-off begins.
// Assumes: the counters are registered, so the outputs depend on registers only.
module can_fc_state
    import can_fc_pkg::*;
#(
    parameter int TEC_W = 9,
    parameter int REC_W = 8,
    parameter int LIM   = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TEC_W-1:0] tec,
    input  logic [REC_W-1:0] rec,
    output fc_state_e        state,
    output logic             busoff,
    output logic             busoff_pulse
);
    localparam logic [TEC_W-1:0] TEC_LIM_V = TEC_W'(LIM);
    localparam logic [REC_W-1:0] REC_LIM_V = REC_W'(LIM);
    localparam logic [TEC_W-1:0] OFF_LIM_V = TEC_W'(2 * LIM + 1);

    logic busoff_q;

    // Map the counter levels to a state code.
    always_comb begin
        busoff = (tec > OFF_LIM_V);
        if (busoff)                                state = FC_BUSOFF;
        else if (tec > TEC_LIM_V || rec > REC_LIM_V) state = FC_PASSIVE;
        else                                       state = FC_ACTIVE;
    end

    // Remember the previous bus-off level to form the entry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) busoff_q <= 1'b0;
        else        busoff_q <= busoff;
    end

    assign busoff_pulse = busoff & ~busoff_q;
endmodule

// File: rtl/can_fault_confine.sv
// CAN fault confinement counter unit (top).
// Merges the protocol-engine event pulses into counter steps, keeps the
// transmit and receive counters, and reports the confinement state.
// Assumes: events are single-cycle pulses whose qualifiers are valid in the
// same cycle; while bus-off, only clr_i acts.
module can_fault_confine
    import can_fc_pkg::*;
#(
    parameter int TEC_W   = 9,
    parameter int REC_W   = 8,
    parameter int LIM     = 127,
    parameter int STEP    = 8,
    parameter int RX_STEP = 1,
    parameter int RELOAD  = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             role_tx_i,
    input  logic             tx_err_i,
    input  logic             tx_err_ackpass_i,
    input  logic             tx_err_arbstuff_i,
    input  logic             rx_err_i,
    input  logic             rx_err_inflag_i,
    input  logic             dom_after_flag_i,
    input  logic             flag_bit_err_i,
    input  logic             dom_run_i,
    input  logic             tx_ok_i,
    input  logic             rx_ok_i,
    input  logic             clr_i,
    output logic [TEC_W-1:0] tec_o,
    output logic [REC_W-1:0] rec_o,
    output logic [1:0]       state_o,
    output logic             busoff_pulse_o
);
    logic      tec_inc, rec_big, rec_small, frozen;
    fc_state_e state;

    // Event merging: which counter moves, and by how much.
    always_comb begin
        tec_inc   = (tx_err_i & ~tx_err_ackpass_i & ~tx_err_arbstuff_i)
                  | (flag_bit_err_i &  role_tx_i)
                  | (dom_run_i      &  role_tx_i);
        rec_big   = (dom_after_flag_i & ~role_tx_i)
                  | (flag_bit_err_i   & ~role_tx_i)
                  | (dom_run_i        & ~role_tx_i);
        rec_small = rx_err_i & ~rx_err_inflag_i;
    end

    can_fc_tec #(.W(TEC_W), .STEP(STEP)) u_tec (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_i),
        .freeze (frozen),
        .inc    (tec_inc),
        .dec    (tx_ok_i),
        .cnt    (tec_o)
    );

    can_fc_rec #(.W(REC_W), .SMALL(RX_STEP), .BIG(STEP), .LIM(LIM), .RELOAD(RELOAD)) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_i),
        .freeze    (frozen),
        .inc_small (rec_small),
        .inc_big   (rec_big),
        .ok        (rx_ok_i),
        .cnt       (rec_o)
    );

    can_fc_state #(.TEC_W(TEC_W), .REC_W(REC_W), .LIM(LIM)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .tec          (tec_o),
        .rec          (rec_o),
        .state        (state),
        .busoff       (frozen),
        .busoff_pulse (busoff_pulse_o)
    );

    assign state_o = state;
endmodule

// File: rtl/can_fc_chk.sv
// Property checker for can_fault_confine, attached by bind.
module can_fc_chk #(
    parameter int TEC_W = 9,
    parameter int REC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_err_i,
    input logic             tx_err_ackpass_i,
    input logic             tx_err_arbstuff_i,
    input logic             flag_bit_err_i,
    input logic             dom_run_i,
    input logic             tx_ok_i,
    input logic             clr_i,
    input logic [TEC_W-1:0] tec_o,
    input logic [REC_W-1:0] rec_o,
    input logic [1:0]       state_o,
    input logic             busoff_pulse_o
);
    // R1
    tec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'b10 && !clr_i && tx_err_i && !tx_err_ackpass_i && !tx_err_arbstuff_i)
        |=> (tec_o == $past(tec_o) + 9'd8));

    // R8
    tec_exempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && tx_err_i && (tx_err_ackpass_i || tx_err_arbstuff_i)
         && !flag_bit_err_i && !dom_run_i && !tx_ok_i)
        |=> $stable(tec_o));

    // R9
    passive_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b01) |-> ((tec_o > 9'd127 || rec_o > 8'd127) && tec_o <= 9'd255));

    // R10
    busoff_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10) |-> (tec_o > 9'd255));

    // R10
    busoff_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_pulse_o |-> (state_o == 2'b10) ##1 !busoff_pulse_o);

    // R11
    busoff_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10 && !clr_i) |=> ($stable(tec_o) && $stable(rec_o)));

    // R12
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (tec_o == '0 && rec_o == '0 && state_o == 2'b00));
endmodule

bind can_fault_confine can_fc_chk #(.TEC_W(TEC_W), .REC_W(REC_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .tx_err_i          (tx_err_i),
    .tx_err_ackpass_i  (tx_err_ackpass_i),
    .tx_err_arbstuff_i (tx_err_arbstuff_i),
    .flag_bit_err_i    (flag_bit_err_i),
    .dom_run_i         (dom_run_i),
    .tx_ok_i           (tx_ok_i),
    .clr_i             (clr_i),
    .tec_o             (tec_o),
    .rec_o             (rec_o),
    .state_o           (state_o),
    .busoff_pulse_o    (busoff_pulse_o)
);

// File: tb/tb_can_fault_confine.sv
// Scoreboard bench: the driver pushes the expected outcome of each event,
// and the monitor pops it at the falling edge after the event's clock edge.
module tb_can_fault_confine;
    localparam int B_ROLE = 0, B_TXE = 1, B_ACKP = 2, B_ARB = 3, B_RXE = 4,
                   B_INFL = 5, B_DAF = 6, B_FBE = 7, B_DRUN = 8, B_TXOK = 9,
                   B_RXOK = 10, B_CLR = 11;

    typedef struct {
        int    tec;
        int    rec;
        int    st;
        int    pulse;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ev = '0;
    logic [8:0]  tec_o;
    logic [7:0]  rec_o;
    logic [1:0]  state_o;
    logic        busoff_pulse_o;

    int   checks = 0;
    int   errors = 0;
    int   mtec = 0;
    int   mrec = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    can_fault_confine dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .role_tx_i         (ev[B_ROLE]),
        .tx_err_i          (ev[B_TXE]),
        .tx_err_ackpass_i  (ev[B_ACKP]),
        .tx_err_arbstuff_i (ev[B_ARB]),
        .rx_err_i          (ev[B_RXE]),
        .rx_err_inflag_i   (ev[B_INFL]),
        .dom_after_flag_i  (ev[B_DAF]),
        .flag_bit_err_i    (ev[B_FBE]),
        .dom_run_i         (ev[B_DRUN]),
        .tx_ok_i           (ev[B_TXOK]),
        .rx_ok_i           (ev[B_RXOK]),
        .clr_i             (ev[B_CLR]),
        .tec_o             (tec_o),
        .rec_o             (rec_o),
        .state_o           (state_o),
        .busoff_pulse_o    (busoff_pulse_o)
    );

    function automatic int st_of(input int t, input int r);
        if (t > 255)            return 2;
        if (t > 127 || r > 127) return 1;
        return 0;
    endfunction

    // Driver: apply one event for one cycle, then push its expected outcome.
    task automatic drive(input logic [11:0] e, input string tag);
        exp_t x;
        bit   was_off, role;
        @(negedge clk);
        ev = e;
        @(posedge clk);
        #1;
        ev = '0;
        was_off = (mtec > 255);
        role    = e[B_ROLE];
        if (e[B_CLR]) begin
            mtec = 0;
            mrec = 0;
        end else if (!was_off) begin
            if ((e[B_TXE] && !e[B_ACKP] && !e[B_ARB]) || ((e[B_FBE] || e[B_DRUN]) && role))
                mtec = mtec + 8;
            else if (e[B_TXOK] && mtec > 0)
                mtec = mtec - 1;
            if (((e[B_DAF] || e[B_FBE] || e[B_DRUN]) && !role))
                mrec = (mrec + 8 > 255) ? 255 : mrec + 8;
            else if (e[B_RXE] && !e[B_INFL])
                mrec = (mrec + 1 > 255) ? 255 : mrec + 1;
            else if (e[B_RXOK])
                mrec = (mrec > 127) ? 127 : ((mrec > 0) ? mrec - 1 : 0);
        end
        x.tec   = mtec;
        x.rec   = mrec;
        x.st    = st_of(mtec, mrec);
        x.pulse = (!was_off && mtec > 255) ? 1 : 0;
        x.tag   = tag;
        exp_q.push_back(x);
    endtask

    // Monitor: compare outputs with the oldest expected item.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            checks++;
            if (int'(tec_o) != x.tec || int'(rec_o) != x.rec ||
                int'(state_o) != x.st || int'(busoff_pulse_o) != x.pulse) begin
                errors++;
                $display("FAIL %s: tec=%0d rec=%0d st=%0d pulse=%0d expected tec=%0d rec=%0d st=%0d pulse=%0d",
                         x.tag, tec_o, rec_o, state_o, busoff_pulse_o, x.tec, x.rec, x.st, x.pulse);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [11:0] ROLE = 12'(1) << B_ROLE;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state: counters zero, error active
        checks++;
        if (tec_o != 0 || rec_o != 0 || state_o != 2'b00 || busoff_pulse_o != 1'b0) begin
            errors++;
            $display("FAIL R9 reset: tec=%0d rec=%0d st=%0d expected 0 0 0", tec_o, rec_o, state_o);
        end

        drive(ROLE | (12'(1) << B_TXE), "R1 tx error");
        for (int i = 0; i < 9; i++) drive(ROLE | (12'(1) << B_TXOK), "R2 tx ok / floor");
        drive(12'(1) << B_RXE, "R3 rx error");
        drive((12'(1) << B_RXE) | (12'(1) << B_INFL), "R3 rx error in flag ignored");
        drive(12'(1) << B_DAF, "R4 dominant after flag rx");
        drive(ROLE | (12'(1) << B_DAF), "R4 dominant after flag tx ignored");
        drive(ROLE | (12'(1) << B_FBE), "R5 flag bit error tx");
        drive(12'(1) << B_FBE, "R5 flag bit error rx");
        drive(ROLE | (12'(1) << B_DRUN), "R6 dominant run tx");
        drive(12'(1) << B_DRUN, "R6 dominant run rx");
        drive(ROLE | (12'(1) << B_TXE) | (12'(1) << B_ACKP), "R8 ack passive exception");
        drive(ROLE | (12'(1) << B_TXE) | (12'(1) << B_ARB), "R8 arbitration stuff exception");
        drive(12'(1) << B_RXOK, "R7 rx ok decrement");
        for (int i = 0; i < 12; i++) drive(12'(1) << B_DAF, "R9 rec rising active");
        for (int i = 0; i < 7; i++) drive(12'(1) << B_RXE, "R9 rec at 127 active");
        drive(12'(1) << B_RXE, "R9 rec 128 passive");
        for (int i = 0; i < 9; i++) drive(12'(1) << B_DAF, "R9 rec high passive");
        drive(12'(1) << B_RXOK, "R7 reload above limit");
        for (int i = 0; i < 17; i++) drive(12'(1) << B_DAF, "R13 rec saturation");
        drive(12'(1) << B_RXE, "R13 rec held at max, R10 no bus-off from rec");
        drive(12'(1) << B_CLR, "R12 clear");
        for (int i = 0; i < 31; i++) drive(ROLE | (12'(1) << B_TXE), "R9 tec to passive");
        drive(ROLE | (12'(1) << B_TXE), "R10 bus-off entry");
        drive('0, "R10 pulse single cycle");
        drive(ROLE | (12'(1) << B_TXOK), "R11 tx ok ignored in bus-off");
        drive(12'(1) << B_DAF, "R11 rx event ignored in bus-off");
        drive(ROLE | (12'(1) << B_TXE), "R11 tx error ignored in bus-off");
        drive(12'(1) << B_CLR, "R12 clear from bus-off");
        drive(12'(1) << B_RXOK, "R7 rx ok at zero");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule